// File: doc/BRIEF.md
# Block Byte Search Engine

This sequencer walks through memory and looks for a byte equal to an 8-bit key value. A start command loads a 16-bit address pointer, a 16-bit byte count, the key and a two-bit mode. For each step the engine reads one byte through a read-only synchronous memory port. It compares that byte with the key, moves the pointer by one and reduces the count by one.

In single-step mode the engine performs exactly one step. In repeat mode it keeps stepping until the byte read equals the key or until the count runs out, whichever comes first. The direction bit chooses whether the pointer rises or falls.

When the scan ends, the engine raises a one-cycle done pulse. It presents the final pointer and count together with five flags: zero, sign, half-carry, subtract and parity/overflow. The surrounding logic reads these flags to learn whether the scan ended on a match or because the count was used up. The key is only read and is never modified. The engine has no carry output, so it cannot change a carry.

Top module: `byte_scan`

## Requirements
- R1: While reset is asserted, and after reset until the first start, done and mem_rd are 0, and ptr_out, cnt_out and all five flags are 0.
- R2: A start in idle captures ptr_init, cnt_init, acc and mode. Every step issues one mem_rd pulse with mem_addr equal to the current pointer, and mem_rd is never high on two cycles in a row. The first read address is ptr_init.
- R3: Each step computes D = acc - byte and sets the flags as follows:
  - flag_z is 1 exactly when the byte equals acc.
  - flag_s is bit 7 of D.
  - flag_h is 1 when the low nibble of acc is less than the low nibble of the byte (a borrow out of bit 3).
  - flag_n is 1.
- R4: Each step moves the pointer by +1 when mode[0]=0 (ascending) or by -1 when mode[0]=1 (descending), wrapping modulo 65536. Each step also decrements the count by 1.
- R5: After each step, flag_pv is 1 when the new count is nonzero and 0 when it is zero.
- R6: With mode[1]=0 (single step) the scan performs exactly one read and then pulses done.
- R7: With mode[1]=1 (repeat) the scan stops at the first byte equal to acc. The pointer and count are still updated on that step, so ptr_out is one past the match in the scan direction.
- R8: In repeat mode, a scan that finds no match stops when the count reaches zero, and then flag_pv is 0.
- R9: A starting count of 0 means 65536 bytes. After one step cnt_out is 16'hFFFF and flag_pv is 1.
- R10: A start pulse that arrives while a scan is in progress is ignored. The scan finishes with the results of the original command.
- R11: done is high for exactly one cycle per scan. After done, ptr_out, cnt_out and the flags hold their values until the next start.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Start command, sampled in idle |
| mode | input | 2 | bit 0: 1 = descending; bit 1: 1 = repeat |
| acc | input | 8 | Key value to search for |
| ptr_init | input | 16 | Starting address pointer |
| cnt_init | input | 16 | Starting byte count (0 means 65536) |
| mem_rd | output | 1 | Memory read strobe |
| mem_addr | output | 16 | Memory read address |
| mem_rdata | input | 8 | Read data, valid on the cycle after mem_rd |
| done | output | 1 | One-cycle end-of-scan pulse |
| ptr_out | output | 16 | Current or final pointer |
| cnt_out | output | 16 | Current or final count |
| flag_z | output | 1 | Byte equal to key |
| flag_s | output | 1 | Sign of key minus byte |
| flag_h | output | 1 | Borrow from the low nibble |
| flag_n | output | 1 | Subtract flag |
| flag_pv | output | 1 | Count still nonzero |

## Verification
A wrong pointer shows up at mem_addr on the very next read strobe, two cycles after the step that produced it, long before the scan ends. A count off by one, or a lost termination condition, shows up when done arrives. Done may come too early or too late, so the number of read strobes is wrong, or flag_pv disagrees with cnt_out. A mode bit that was captured wrongly shows up as reads that move in the wrong direction, or as a single-step scan that makes more than one read.

// File: rtl/byte_scan.sv
module byte_scan #(
  parameter int AW = 16,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [1:0]    mode,
  input  logic [DW-1:0] acc,
  input  logic [AW-1:0] ptr_init,
  input  logic [AW-1:0] cnt_init,
  output logic          mem_rd,
  output logic [AW-1:0] mem_addr,
  input  logic [DW-1:0] mem_rdata,
  output logic          done,
  output logic [AW-1:0] ptr_out,
  output logic [AW-1:0] cnt_out,
  output logic          flag_z,
  output logic          flag_s,
  output logic          flag_h,
  output logic          flag_n,
  output logic          flag_pv
);

  typedef enum logic [1:0] {S_IDLE, S_READ, S_CMP} st_t;

  st_t           st;
  logic          desc_q;
  logic          rep_q;
  logic [DW-1:0] key_q;
  logic [AW-1:0] ptr_q;
  logic [AW-1:0] cnt_q;

  logic [DW:0]   diff;
  logic [4:0]    nib;
  logic [AW-1:0] cnt_nx;
  logic [AW-1:0] ptr_nx;
  logic          hit;
  logic          more;

  assign diff   = {1'b0, key_q} - {1'b0, mem_rdata};
  assign nib    = {1'b0, key_q[3:0]} - {1'b0, mem_rdata[3:0]};
  assign cnt_nx = cnt_q - 1'b1;
  assign ptr_nx = desc_q ? ptr_q - 1'b1 : ptr_q + 1'b1;
  assign hit    = (mem_rdata == key_q);
  assign more   = (cnt_nx != '0);

  assign mem_rd   = (st == S_READ);
  assign mem_addr = ptr_q;
  assign ptr_out  = ptr_q;
  assign cnt_out  = cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      desc_q  <= 1'b0;
      rep_q   <= 1'b0;
      key_q   <= '0;
      ptr_q   <= '0;
      cnt_q   <= '0;
      done    <= 1'b0;
      flag_z  <= 1'b0;
      flag_s  <= 1'b0;
      flag_h  <= 1'b0;
      flag_n  <= 1'b0;
      flag_pv <= 1'b0;
    end else begin
      done <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          desc_q <= mode[0];
          rep_q  <= mode[1];
          key_q  <= acc;
          ptr_q  <= ptr_init;
          cnt_q  <= cnt_init;
          st     <= S_READ;
        end
        S_READ: st <= S_CMP;
        S_CMP: begin
          ptr_q   <= ptr_nx;
          cnt_q   <= cnt_nx;
          flag_z  <= hit;
          flag_s  <= diff[DW-1];
          flag_h  <= nib[4];
          flag_n  <= 1'b1;
          flag_pv <= more;
          if (rep_q && !hit && more) begin
            st <= S_READ;
          end else begin
            st   <= S_IDLE;
            done <= 1'b1;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/byte_scan_chk.sv
module byte_scan_chk #(
  parameter int AW = 16,
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic [1:0]    mode,
  input logic [DW-1:0] acc,
  input logic          mem_rd,
  input logic [AW-1:0] mem_addr,
  input logic [DW-1:0] mem_rdata,
  input logic          done,
  input logic [AW-1:0] ptr_out,
  input logic [AW-1:0] cnt_out,
  input logic          flag_z,
  input logic          flag_n,
  input logic          flag_pv
);

  logic          busy_c;
  logic          desc_c;
  logic          rep_c;
  logic [DW-1:0] key_c;
  logic [AW-1:0] last_addr;
  logic [DW-1:0] last_data;
  logic          rd_pend;
  logic [AW+1:0] reads_c;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_c    <= 1'b0;
      desc_c    <= 1'b0;
      rep_c     <= 1'b0;
      key_c     <= '0;
      last_addr <= '0;
      last_data <= '0;
      rd_pend   <= 1'b0;
      reads_c   <= '0;
    end else begin
      rd_pend <= mem_rd;
      if (rd_pend) last_data <= mem_rdata;
      if (start && (!busy_c || done)) begin
        busy_c  <= 1'b1;
        desc_c  <= mode[0];
        rep_c   <= mode[1];
        key_c   <= acc;
        reads_c <= '0;
      end else if (done) begin
        busy_c <= 1'b0;
      end
      if (mem_rd) begin
        last_addr <= mem_addr;
        reads_c   <= reads_c + 1'b1;
      end
    end
  end

  p_rd_stride_r2: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd |=> !mem_rd);

  p_zero_match_r3: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (flag_n && (flag_z == (last_data == key_c))));

  p_step_addr_r4: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (ptr_out == (desc_c ? last_addr - 1'b1 : last_addr + 1'b1)));

  p_pv_count_r5: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (flag_pv == (cnt_out != '0)));

  p_single_read_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !rep_c) |-> (reads_c == 1));

  // R7 and R8: a repeat scan ends only on a match or on exhaustion
  p_repeat_stop_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (done && rep_c) |-> (flag_z || !flag_pv));

  p_done_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_c && !start) |=> ($stable(ptr_out) && $stable(cnt_out) && $stable(flag_pv)));

endmodule

bind byte_scan byte_scan_chk #(.AW(AW), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .mode(mode), .acc(acc),
  .mem_rd(mem_rd), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
  .done(done), .ptr_out(ptr_out), .cnt_out(cnt_out),
  .flag_z(flag_z), .flag_n(flag_n), .flag_pv(flag_pv)
);

// File: tb/byte_scan_tb.sv
module byte_scan_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [1:0]  mode = 2'b00;
  logic [7:0]  acc = 8'h00;
  logic [15:0] ptr_init = 16'h0;
  logic [15:0] cnt_init = 16'h0;
  logic        mem_rd;
  logic [15:0] mem_addr;
  logic [7:0]  mem_rdata = 8'h00;
  logic        done;
  logic [15:0] ptr_out, cnt_out;
  logic        flag_z, flag_s, flag_h, flag_n, flag_pv;

  always #4 clk = ~clk;

  byte_scan u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .mode(mode), .acc(acc),
    .ptr_init(ptr_init), .cnt_init(cnt_init),
    .mem_rd(mem_rd), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
    .done(done), .ptr_out(ptr_out), .cnt_out(cnt_out),
    .flag_z(flag_z), .flag_s(flag_s), .flag_h(flag_h), .flag_n(flag_n), .flag_pv(flag_pv)
  );

  function automatic logic [7:0] memf(input logic [15:0] a);
    return a[7:0] ^ {a[11:8], a[15:12]};
  endfunction

  always @(posedge clk) if (mem_rd) mem_rdata <= memf(mem_addr);

  typedef struct {
    logic [15:0] p0;
    logic        dsc;
    logic [15:0] p;
    logic [15:0] c;
    logic        z, s, h, pv;
    int          reads;
    string       req;
  } exp_t;

  exp_t q[$];
  exp_t last;
  int n_cmp = 0, n_bad = 0, n_exp = 0, n_done = 0;
  int rd_cnt = 0;
  logic [15:0] exp_addr = 16'h0;
  logic done_prev = 1'b0;
  bit finished = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] expv);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, expv);
    end
  endtask

  function automatic exp_t model(input logic [15:0] p, input logic [15:0] c,
                                 input logic [7:0] a, input logic [1:0] m, input string req);
    exp_t e;
    logic [7:0] b;
    logic [8:0] d;
    logic [4:0] nb;
    e.p0 = p; e.dsc = m[0]; e.reads = 0; e.req = req;
    forever begin
      b = memf(p);
      e.reads++;
      d = {1'b0, a} - {1'b0, b};
      nb = {1'b0, a[3:0]} - {1'b0, b[3:0]};
      e.z = (b == a); e.s = d[7]; e.h = nb[4];
      c = c - 16'd1;
      p = m[0] ? p - 16'd1 : p + 16'd1;
      e.pv = (c != 16'd0);
      if (!m[1] || e.z || !e.pv) break;
    end
    e.p = p; e.c = c;
    return e;
  endfunction

  task automatic pulse_start(input logic [15:0] p, input logic [15:0] c,
                             input logic [7:0] a, input logic [1:0] m);
    @(negedge clk);
    start = 1'b1; ptr_init = p; cnt_init = c; acc = a; mode = m;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic scan(input logic [15:0] p, input logic [15:0] c,
                      input logic [7:0] a, input logic [1:0] m, input string req);
    last = model(p, c, a, m, req);
    q.push_back(last);
    n_exp++;
    pulse_start(p, c, a, m);
    wait (n_done == n_exp);
    repeat (3) @(negedge clk);
    chk(ptr_out == last.p && cnt_out == last.c && flag_pv == last.pv,
        "R11", "hold after done", {ptr_out, cnt_out}, {last.p, last.c});
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      if (mem_rd) begin
        if (q.size() == 0) begin
          chk(0, "R10", "unexpected read", 32'(mem_addr), 32'h0);
        end else begin
          if (rd_cnt == 0) exp_addr = q[0].p0;
          chk(mem_addr == exp_addr, "R2", "read address", 32'(mem_addr), 32'(exp_addr));
          exp_addr = q[0].dsc ? exp_addr - 16'd1 : exp_addr + 16'd1;
          rd_cnt++;
        end
      end
      if (done && done_prev) chk(0, "R11", "done width", 32'd2, 32'd1);
      if (done) begin
        if (q.size() == 0) begin
          chk(0, "R11", "unexpected done", 32'd1, 32'd0);
        end else begin
          exp_t e;
          e = q.pop_front();
          chk(ptr_out == e.p, e.req, "ptr_out (R4)", 32'(ptr_out), 32'(e.p));
          chk(cnt_out == e.c, e.req, "cnt_out (R4)", 32'(cnt_out), 32'(e.c));
          chk({flag_z, flag_s, flag_h, flag_n} == {e.z, e.s, e.h, 1'b1}, e.req,
              "z,s,h,n (R3)", 32'({flag_z, flag_s, flag_h, flag_n}), 32'({e.z, e.s, e.h, 1'b1}));
          chk(flag_pv == e.pv, e.req, "pv (R5)", 32'(flag_pv), 32'(e.pv));
          chk(rd_cnt == e.reads, e.req, "read count", 32'(rd_cnt), 32'(e.reads));
        end
        rd_cnt = 0;
        n_done++;
      end
      done_prev = done;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk({done, mem_rd, ptr_out, cnt_out, flag_z, flag_s, flag_h, flag_n, flag_pv} == '0,
        "R1", "reset state", {ptr_out, cnt_out}, 32'h0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk({done, mem_rd, ptr_out, cnt_out, flag_n, flag_pv} == '0,
        "R1", "idle after reset", {ptr_out, cnt_out}, 32'h0);

    scan(16'h0100, 16'd5,  8'h99, 2'b00, "R6 single asc");
    scan(16'h0203, 16'd1,  8'h23, 2'b01, "R6 single desc match");
    scan(16'h0201, 16'd4,  8'h10, 2'b00, "R3 sign/half");
    scan(16'h0201, 16'd4,  8'h80, 2'b00, "R3 half only");
    scan(16'h0100, 16'd50, 8'h00, 2'b10, "R7 repeat asc match");
    scan(16'h0300, 16'd8,  8'hFF, 2'b11, "R8 repeat desc exhaust");
    scan(16'h0001, 16'd10, 8'h00, 2'b11, "R7 desc wrap match");
    scan(16'hFFFF, 16'd3,  8'h77, 2'b00, "R4 asc wrap");
    scan(16'h0400, 16'd0,  8'h55, 2'b00, "R9 count zero");
    scan(16'h0105, 16'd1,  8'h15, 2'b10, "R8 match on last");

    last = model(16'h0500, 16'd30, 8'hEE, 2'b10, "R10 busy start");
    q.push_back(last);
    n_exp++;
    pulse_start(16'h0500, 16'd30, 8'hEE, 2'b10);
    repeat (9) @(negedge clk);
    start = 1'b1; ptr_init = 16'h0700; cnt_init = 16'd2; acc = 8'h07; mode = 2'b01;
    @(negedge clk);
    start = 1'b0;
    wait (n_done == n_exp);
    repeat (4) @(negedge clk);
    chk(ptr_out == last.p && !done && !mem_rd, "R10", "no second scan",
        32'(ptr_out), 32'(last.p));

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule